// File: doc/BRIEF.md
# ADC External Trigger Control Register

This block holds the 8-bit control byte that decides whether an analog-to-digital converter may be started from an external trigger pin, and it contains the pin logic that turns a falling edge on that pin into a start request. Software reaches the byte over a simple register bus with an address compare, a write strobe and a read strobe. The converter and its channel sequencer are outside the block and see only a one-clock start pulse and a scan-select level.

The trigger pin is asynchronous. It passes through two synchronizing flops and an edge detector. When the two-bit enable field holds the value 3, each detected falling edge produces exactly one start pulse. Any other enable value discards the edge for good. Bit 5 selects scan or multi operation for the sequencer, and it matters only when the sequencer's own multi-mode control is on. The low five bits are fixed reserved fields. A reset or a standby request loads the byte with 0x07.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, a read of the register returns 0x07 and scan_sel is 0.
- R2: While standby is high at a rising clock edge, the register returns to 0x07. This takes priority over a write in the same cycle.
- R3: A write to the register address stores bits 7:6 as the trigger-enable code and bit 5 as the scan select. A later read returns them in the same positions, and scan_sel follows bit 5.
- R4: Bits 4:3 always read 0 and bits 2:0 always read 1, whatever value was written.
- R5: With enable code 0, 1 or 2, a falling edge on trig_n produces no start pulse.
- R6: With enable code 3, a falling edge on trig_n makes conv_start high for exactly one clock. That clock is the period that follows the third rising clock edge after the pin goes low.
- R7: A rising edge on trig_n, or a pin held low, produces no start pulse.
- R8: A falling edge that is detected while the enable code is not 3 is lost. Writing code 3 afterwards, with the pin still low, starts nothing.
- R9: bus_rdata is 0 unless bus_rd is high and bus_addr equals the register address. A write to any other address leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous request to reload the register with its reset value |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| trig_n | input | 1 | Asynchronous external trigger pin, active on its falling edge |
| conv_start | output | 1 | One-clock conversion start request |
| scan_sel | output | 1 | Scan (1) or multi (0) selection for the sequencer |

## Verification
The hardest case to reach is R8. In that case a falling edge has to be detected while the trigger is disabled, and the enable is then raised while the pin stays low, so the bench has to show that no stale edge is left pending. The stimulus drops the pin with the code at 0 and waits out the synchronizer latency. It then writes code 3 and watches several clocks for a pulse. After that it raises the pin to also cover the R7 case. The bench also counts the clock of the start pulse for each falling edge, which pins the R6 latency exactly.

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              trig_n,
  output logic              conv_start,
  output logic              scan_sel
);

  localparam logic [1:0] EN_ARMED = 2'b11;

  logic [1:0] en_code;
  logic       scan_q;
  logic       hit;
  logic [2:0] pin_sh;
  logic       fall;
  logic       start_q;
  logic       unused_wbits;

  assign hit          = bus_addr == REG_ADDR;
  assign unused_wbits = ^bus_wdata[4:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_code <= 2'b00;
      scan_q  <= 1'b0;
    end else if (standby) begin
      en_code <= 2'b00;
      scan_q  <= 1'b0;
    end else if (bus_wr && hit) begin
      en_code <= bus_wdata[7:6];
      scan_q  <= bus_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sh  <= 3'b111;
      start_q <= 1'b0;
    end else begin
      pin_sh  <= {pin_sh[1:0], trig_n};
      start_q <= fall && (en_code == EN_ARMED);
    end
  end

  assign fall       = pin_sh[2] && !pin_sh[1];
  assign conv_start = start_q;
  assign scan_sel   = scan_q;
  assign bus_rdata  = (bus_rd && hit) ? {en_code, scan_q, 2'b00, 3'b111} : 8'h00;

  // R6
  start_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R5
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(en_code) == EN_ARMED);

  // R2
  standby_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (en_code == 2'b00) && !scan_sel);

  // R4
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit) |-> (bus_rdata[4:0] == 5'b00111));

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && hit) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/adc_trig_ctrl_test.sv
module adc_trig_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       trig_n = 1'b1;
  logic       conv_start;
  logic       scan_sel;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] RA = 4'h2;

  adc_trig_ctrl #(.ADDR_W(4), .REG_ADDR(4'h2)) uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .trig_n(trig_n), .conv_start(conv_start),
    .scan_sel(scan_sel)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pin_watch(input logic lvl, input int n, output int cnt, output int first);
    @(negedge clk);
    trig_n = lvl;
    cnt = 0; first = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (conv_start) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(RA, d);
    check("R1 reset value", d, 8'h07);
    check("R1 scan_sel", scan_sel, 0);
    @(negedge clk);
    #1 check("R9 idle rdata", bus_rdata, 0);
  endtask

  task automatic t_write_read;
    logic [7:0] d;
    wr(RA, 8'hFF);
    rd(RA, d);
    check("R3 R4 write ff", d, 8'hE7);
    check("R3 scan_sel high", scan_sel, 1);
    wr(RA, 8'h40);
    rd(RA, d);
    check("R3 R4 write 40", d, 8'h47);
    check("R3 scan_sel low", scan_sel, 0);
    wr(RA, 8'h18);
    rd(RA, d);
    check("R4 reserved ignored", d, 8'h07);
    wr(4'h5, 8'hE0);
    rd(RA, d);
    check("R9 other address write", d, 8'h07);
    rd(4'h5, d);
    check("R9 other address read", d, 0);
  endtask

  task automatic t_disabled_codes;
    int cnt, first;
    for (int c = 0; c < 3; c++) begin
      wr(RA, 8'(c << 6));
      pin_watch(1'b0, 6, cnt, first);
      check("R5 disabled code no start", cnt, 0);
      pin_watch(1'b1, 6, cnt, first);
      check("R7 rising no start", cnt, 0);
    end
  endtask

  task automatic t_armed;
    int cnt, first;
    wr(RA, 8'hC0);
    pin_watch(1'b0, 8, cnt, first);
    check("R6 one pulse", cnt, 1);
    check("R6 pulse clock", first, 3);
    pin_watch(1'b0, 8, cnt, first);
    check("R7 held low", cnt, 0);
    pin_watch(1'b1, 8, cnt, first);
    check("R7 rising edge", cnt, 0);
    pin_watch(1'b0, 8, cnt, first);
    check("R6 second edge", cnt, 1);
    pin_watch(1'b1, 4, cnt, first);
  endtask

  task automatic t_stale_edge;
    int cnt, first;
    wr(RA, 8'h00);
    pin_watch(1'b0, 5, cnt, first);
    check("R8 edge while disabled", cnt, 0);
    wr(RA, 8'hC0);
    pin_watch(1'b0, 8, cnt, first);
    check("R8 stale edge after arm", cnt, 0);
    pin_watch(1'b1, 6, cnt, first);
    check("R7 rising after arm", cnt, 0);
  endtask

  task automatic t_standby;
    logic [7:0] d;
    int cnt, first;
    wr(RA, 8'hE0);
    @(negedge clk);
    standby = 1'b1; bus_addr = RA; bus_wdata = 8'hE0; bus_wr = 1'b1;
    @(negedge clk);
    standby = 1'b0; bus_wr = 1'b0;
    rd(RA, d);
    check("R2 standby reload", d, 8'h07);
    check("R2 scan_sel cleared", scan_sel, 0);
    pin_watch(1'b0, 6, cnt, first);
    check("R2 standby disarms", cnt, 0);
    pin_watch(1'b1, 4, cnt, first);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_disabled_codes();
    t_armed();
    t_stale_edge();
    t_standby();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule